// File: doc/BRIEF.md
# Chroma Block Intra Predictor

This block builds the 8x8 intra prediction for one chroma colour plane from its already reconstructed neighbours. It takes the eight samples above the block, the eight samples to its left, a mode field, and three availability flags: one for the row above, one for the upper four rows of the left column and one for the lower four rows of the left column. A one-cycle start pulse latches all of these. The block then streams the predicted block out one row per cycle, with a row index and a valid strobe, and pulses a completion flag after the last row.

Three modes are produced here: DC, horizontal and vertical. In DC mode each 4x4 quadrant gets its own flat value. Each quadrant has its own rule for choosing between its top and left neighbours, and those rules depend on the split left availability. Plane mode is not computed here. A start in plane mode is passed on to a separate unit through a one-cycle handoff pulse, and this block emits no rows for it.

Top module: `chroma_intra_pred`

## Requirements
- R1: Only bits [1:0] of `mode_i` select the mode: 0 gives DC, 1 gives horizontal, 2 gives vertical and 3 gives plane. The higher bits have no effect.
- R2: A `start` pulse while idle latches the mode, the flags and both neighbour vectors. Rows 0 to 7 then appear on eight consecutive cycles, starting the cycle after the start edge, with `row_valid` high and `row_idx` giving the row. Sample x of each row is `row_data[8x+7:8x]`. Neighbour x is `top_i[8x+7:8x]` and neighbour y is `left_i[8y+7:8y]`.
- R3: `done` is high for exactly one cycle, the cycle after row 7, and `row_valid` is low in that cycle.
- R4: A `start` that arrives while rows are streaming is ignored. The rows in progress, their data and `plane_go` are unaffected.
- R5: In horizontal mode, every sample of row y equals left neighbour y.
- R6: In vertical mode, sample x of every row equals top neighbour x.
- R7: DC for the top-left quadrant uses top 0..3 and left 0..3. DC for the bottom-right quadrant uses top 4..7 and left 4..7. The top set depends on the top flag and the left set depends on the matching left-half flag. With both sets available the value is (sum of 8 + 4) >> 3. With one set it is (sum of 4 + 2) >> 2.
- R8: DC for the top-right quadrant is (sum of top 4..7 + 2) >> 2 when the top is available. Otherwise it is (sum of left 0..3 + 2) >> 2 when the upper left half is available.
- R9: DC for the bottom-left quadrant is (sum of left 4..7 + 2) >> 2 when the lower left half is available. Otherwise it is (sum of top 0..3 + 2) >> 2 when the top is available.
- R10: A DC quadrant with none of its candidate neighbours available predicts 128.
- R11: A start in plane mode raises `plane_go` for one cycle, the cycle after the start edge. It produces no rows and no `done`.
- R12: After reset, `row_valid`, `done` and `plane_go` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch inputs and begin a block |
| mode_i | input | 8 | Mode field; bits [1:0] select the mode |
| top_avail | input | 1 | Row above is available |
| left_up_avail | input | 1 | Left rows 0..3 are available |
| left_dn_avail | input | 1 | Left rows 4..7 are available |
| top_i | input | 64 | Eight top neighbours, sample x at bits [8x+7:8x] |
| left_i | input | 64 | Eight left neighbours, sample y at bits [8y+7:8y] |
| row_valid | output | 1 | A predicted row is present |
| row_idx | output | 3 | Index of the present row |
| row_data | output | 64 | Predicted row, sample x at bits [8x+7:8x] |
| done | output | 1 | Pulse after the last row |
| plane_go | output | 1 | Plane-mode handoff pulse |

## Verification
The assertions check the stream shape on every cycle. They cover the first row after an accepted start, the step from one row index to the next, the single completion pulse after row 7, the plane handoff with no rows, and that a start during streaming never causes a handoff. They also check that horizontal rows are uniform and that vertical rows repeat. Only the bench scenarios can show that the sample values are correct: the DC value of each quadrant under all eight availability combinations, the rounding with saturated inputs, the fallback choices, and that the upper mode bits are ignored.

// File: rtl/chroma_pred_pkg.sv
package chroma_pred_pkg;

  typedef enum logic [1:0] {
    CM_DC    = 2'd0,
    CM_HOR   = 2'd1,
    CM_VER   = 2'd2,
    CM_PLANE = 2'd3
  } cmode_t;

  // Flat value from up to two groups of four samples.
  function automatic logic [15:0] dc_value(input logic [15:0] sa, input logic [15:0] sb,
                                           input logic ua, input logic ub,
                                           input logic [15:0] mid);
    if (ua && ub)  return (sa + sb + 16'd4) >> 3;
    else if (ua)   return (sa + 16'd2) >> 2;
    else if (ub)   return (sb + 16'd2) >> 2;
    else           return mid;
  endfunction

endpackage

// File: rtl/chroma_dc_calc.sv
module chroma_dc_calc
  import chroma_pred_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int BLK      = 8
) (
  input  logic [BLK*SAMPLE_W-1:0] top_i,
  input  logic [BLK*SAMPLE_W-1:0] left_i,
  input  logic                    top_ok,
  input  logic                    up_ok,
  input  logic                    dn_ok,
  output logic [3:0][SAMPLE_W-1:0] dc_o
);
  localparam int HALF = BLK / 2;
  localparam logic [15:0] MID = 16'(1 << (SAMPLE_W - 1));

  logic [15:0] sum_tl, sum_tr, sum_lu, sum_ld;

  always_comb begin
    sum_tl = '0;
    sum_tr = '0;
    sum_lu = '0;
    sum_ld = '0;
    for (int i = 0; i < HALF; i++) begin
      sum_tl = sum_tl + 16'(top_i[i*SAMPLE_W +: SAMPLE_W]);
      sum_tr = sum_tr + 16'(top_i[(i+HALF)*SAMPLE_W +: SAMPLE_W]);
      sum_lu = sum_lu + 16'(left_i[i*SAMPLE_W +: SAMPLE_W]);
      sum_ld = sum_ld + 16'(left_i[(i+HALF)*SAMPLE_W +: SAMPLE_W]);
    end
  end

  logic [15:0] q_tl, q_tr, q_bl, q_br;

  always_comb begin
    q_tl = dc_value(sum_tl, sum_lu, top_ok, up_ok, MID);
    q_br = dc_value(sum_tr, sum_ld, top_ok, dn_ok, MID);
    if (top_ok) q_tr = dc_value(sum_tr, 16'd0, 1'b1, 1'b0, MID);
    else        q_tr = dc_value(sum_lu, 16'd0, up_ok, 1'b0, MID);
    if (dn_ok)  q_bl = dc_value(sum_ld, 16'd0, 1'b1, 1'b0, MID);
    else        q_bl = dc_value(sum_tl, 16'd0, top_ok, 1'b0, MID);
  end

  assign dc_o[0] = q_tl[SAMPLE_W-1:0];
  assign dc_o[1] = q_tr[SAMPLE_W-1:0];
  assign dc_o[2] = q_bl[SAMPLE_W-1:0];
  assign dc_o[3] = q_br[SAMPLE_W-1:0];

endmodule

// File: rtl/chroma_row_gen.sv
module chroma_row_gen
  import chroma_pred_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int BLK      = 8,
  localparam int IDX_W   = $clog2(BLK)
) (
  input  cmode_t                   mode,
  input  logic [IDX_W-1:0]         row_idx,
  input  logic [BLK*SAMPLE_W-1:0]  top_i,
  input  logic [BLK*SAMPLE_W-1:0]  left_i,
  input  logic [3:0][SAMPLE_W-1:0] dc_i,
  output logic [BLK*SAMPLE_W-1:0]  row_o
);
  localparam int HALF = BLK / 2;

  logic             lower_half;
  logic [SAMPLE_W-1:0] left_sample;

  assign lower_half  = (row_idx >= IDX_W'(HALF));
  assign left_sample = left_i[row_idx*SAMPLE_W +: SAMPLE_W];

  for (genvar x = 0; x < BLK; x++) begin : g_col
    localparam logic RIGHT = (x >= HALF);
    logic [1:0] quad;
    assign quad = {lower_half, RIGHT};
    always_comb begin
      case (mode)
        CM_HOR:  row_o[x*SAMPLE_W +: SAMPLE_W] = left_sample;
        CM_VER:  row_o[x*SAMPLE_W +: SAMPLE_W] = top_i[x*SAMPLE_W +: SAMPLE_W];
        CM_DC:   row_o[x*SAMPLE_W +: SAMPLE_W] = dc_i[quad];
        default: row_o[x*SAMPLE_W +: SAMPLE_W] = '0;
      endcase
    end
  end

endmodule

// File: rtl/chroma_row_seq.sv
module chroma_row_seq #(
  parameter int BLK    = 8,
  localparam int IDX_W = $clog2(BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             row_valid,
  output logic [IDX_W-1:0] row_idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      row_idx   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        row_valid <= 1'b1;
        row_idx   <= '0;
      end else if (row_valid) begin
        if (row_idx == LAST) begin
          row_valid <= 1'b0;
          done      <= 1'b1;
        end else begin
          row_idx <= row_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/chroma_intra_pred.sv
module chroma_intra_pred
  import chroma_pred_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int BLK      = 8,
  parameter int MODE_W   = 8,
  localparam int IDX_W   = $clog2(BLK),
  localparam int VEC_W   = BLK * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              top_avail,
  input  logic              left_up_avail,
  input  logic              left_dn_avail,
  input  logic [VEC_W-1:0]  top_i,
  input  logic [VEC_W-1:0]  left_i,
  output logic              row_valid,
  output logic [IDX_W-1:0]  row_idx,
  output logic [VEC_W-1:0]  row_data,
  output logic              done,
  output logic              plane_go
);
  // Named internal events for the checker.
  logic   accept;
  logic   launch;
  cmode_t mode_in;
  cmode_t mode_q;

  assign mode_in = cmode_t'(mode_i[1:0]);
  assign accept  = start && !row_valid;
  assign launch  = accept && (mode_in != CM_PLANE);

  logic             top_q, up_q, dn_q;
  logic [VEC_W-1:0] top_q_v, left_q_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= CM_DC;
      top_q    <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      top_q_v  <= '0;
      left_q_v <= '0;
      plane_go <= 1'b0;
    end else begin
      plane_go <= accept && (mode_in == CM_PLANE);
      if (accept) begin
        mode_q   <= mode_in;
        top_q    <= top_avail;
        up_q     <= left_up_avail;
        dn_q     <= left_dn_avail;
        top_q_v  <= top_i;
        left_q_v <= left_i;
      end
    end
  end

  logic [3:0][SAMPLE_W-1:0] dc_vals;

  chroma_dc_calc #(.SAMPLE_W(SAMPLE_W), .BLK(BLK)) u_dc (
    .top_i  (top_q_v),
    .left_i (left_q_v),
    .top_ok (top_q),
    .up_ok  (up_q),
    .dn_ok  (dn_q),
    .dc_o   (dc_vals)
  );

  chroma_row_seq #(.BLK(BLK)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .row_valid (row_valid),
    .row_idx   (row_idx),
    .done      (done)
  );

  chroma_row_gen #(.SAMPLE_W(SAMPLE_W), .BLK(BLK)) u_gen (
    .mode    (mode_q),
    .row_idx (row_idx),
    .top_i   (top_q_v),
    .left_i  (left_q_v),
    .dc_i    (dc_vals),
    .row_o   (row_data)
  );

endmodule

// File: rtl/chroma_intra_pred_chk.sv
module chroma_intra_pred_chk
  import chroma_pred_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int BLK      = 8,
  parameter int MODE_W   = 8,
  localparam int IDX_W   = $clog2(BLK),
  localparam int VEC_W   = BLK * SAMPLE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [MODE_W-1:0] mode_i,
  input logic              row_valid,
  input logic [IDX_W-1:0]  row_idx,
  input logic [VEC_W-1:0]  row_data,
  input logic              done,
  input logic              plane_go,
  input cmode_t            mode_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK - 1);

  logic uniform;
  always_comb begin
    uniform = 1'b1;
    for (int i = 1; i < BLK; i++)
      if (row_data[i*SAMPLE_W +: SAMPLE_W] != row_data[SAMPLE_W-1:0]) uniform = 1'b0;
  end

  AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    start && !row_valid && (mode_i[1:0] != 2'd3) |=> row_valid && (row_idx == '0)); // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && (row_idx != LAST) |=> row_valid && (row_idx == $past(row_idx) + 1'b1)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && (row_idx == LAST) |=> done && !row_valid); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && start |=> !plane_go); // R4
  AST_HOR_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && (mode_q == CM_HOR) |-> uniform); // R5
  AST_VER_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && (row_idx != '0) && (mode_q == CM_VER) |-> row_data == $past(row_data)); // R6
  AST_PLANE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    start && !row_valid && (mode_i[1:0] == 2'd3) |=> plane_go && !row_valid); // R11

endmodule

bind chroma_intra_pred chroma_intra_pred_chk #(
  .SAMPLE_W(SAMPLE_W), .BLK(BLK), .MODE_W(MODE_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mode_i    (mode_i),
  .row_valid (row_valid),
  .row_idx   (row_idx),
  .row_data  (row_data),
  .done      (done),
  .plane_go  (plane_go),
  .mode_q    (mode_q)
);

// File: tb/chroma_intra_pred_tb.sv
module chroma_intra_pred_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mode_i = '0;
  logic        top_avail = 1'b0, left_up_avail = 1'b0, left_dn_avail = 1'b0;
  logic [63:0] top_i = '0, left_i = '0;
  logic        row_valid, done, plane_go;
  logic [2:0]  row_idx;
  logic [63:0] row_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_intra_pred dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode_i),
    .top_avail(top_avail), .left_up_avail(left_up_avail), .left_dn_avail(left_dn_avail),
    .top_i(top_i), .left_i(left_i),
    .row_valid(row_valid), .row_idx(row_idx), .row_data(row_data),
    .done(done), .plane_go(plane_go)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int tv(input logic [63:0] v, input int i);
    return int'(v[i*8 +: 8]);
  endfunction

  // Reference: gather the neighbours each quadrant uses, then round.
  function automatic int ref_dc(input int qy, input int qx, input logic ta, input logic ua,
                                input logic da, input logic [63:0] t, input logic [63:0] l);
    int s = 0; int n = 0;
    logic lft = (qy == 0) ? ua : da;
    bit diag = (qy == qx);
    if (diag) begin
      if (ta)  for (int k = 0; k < 4; k++) begin s += tv(t, qx*4+k); n++; end
      if (lft) for (int k = 0; k < 4; k++) begin s += tv(l, qy*4+k); n++; end
    end else if (qy == 0) begin
      if (ta)      for (int k = 0; k < 4; k++) begin s += tv(t, 4+k); n++; end
      else if (ua) for (int k = 0; k < 4; k++) begin s += tv(l, k); n++; end
    end else begin
      if (da)      for (int k = 0; k < 4; k++) begin s += tv(l, 4+k); n++; end
      else if (ta) for (int k = 0; k < 4; k++) begin s += tv(t, k); n++; end
    end
    if (n == 8) return (s + 4) / 8;
    if (n == 4) return (s + 2) / 4;
    return 128;
  endfunction

  function automatic string dc_tag(input int qy, input int qx, input logic ta,
                                   input logic ua, input logic da);
    logic lft = (qy == 0) ? ua : da;
    if (qy == qx) return (ta || lft) ? "R7" : "R10";
    if (qy == 0)  return (ta || ua) ? "R8" : "R10";
    return (da || ta) ? "R9" : "R10";
  endfunction

  function automatic logic [63:0] expect_row(input int md, input int y, input logic ta,
                                            input logic ua, input logic da,
                                            input logic [63:0] t, input logic [63:0] l);
    logic [63:0] r;
    for (int x = 0; x < N; x++) begin
      if (md == 1)      r[x*8 +: 8] = l[y*8 +: 8];
      else if (md == 2) r[x*8 +: 8] = t[x*8 +: 8];
      else              r[x*8 +: 8] = 8'(ref_dc(y/4, x/4, ta, ua, da, t, l));
    end
    return r;
  endfunction

  task automatic issue(input logic [7:0] md, input logic ta, input logic ua, input logic da,
                       input logic [63:0] t, input logic [63:0] l);
    @(negedge clk);
    mode_i = md; top_avail = ta; left_up_avail = ua; left_dn_avail = da;
    top_i = t; left_i = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Checks a whole block; issue() must have just returned.
  task automatic check_block(input string req, input int md, input logic ta, input logic ua,
                             input logic da, input logic [63:0] t, input logic [63:0] l,
                             input int disturb_row);
    for (int y = 0; y < N; y++) begin
      check({req, " R2 valid"}, 64'(row_valid), 64'd1);
      check({req, " R2 index"}, 64'(row_idx), 64'(y));
      if (md == 0) begin
        logic [63:0] e = expect_row(0, y, ta, ua, da, t, l);
        for (int x = 0; x < N; x++)
          check(dc_tag(y/4, x/4, ta, ua, da), 64'(row_data[x*8 +: 8]), 64'(e[x*8 +: 8]));
      end else begin
        check(req, row_data, expect_row(md, y, ta, ua, da, t, l));
      end
      if (y == disturb_row) begin
        mode_i = 8'h03; top_i = ~t; left_i = ~l; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (disturb_row >= 0) check("R4 no plane_go", 64'(plane_go), 64'd0);
    end
    check("R3 done", 64'(done), 64'd1);
    check("R3 valid low", 64'(row_valid), 64'd0);
    @(negedge clk);
    check("R3 done pulse", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] pattern(input int p, input int salt);
    logic [63:0] v;
    for (int i = 0; i < N; i++)
      case (p)
        0: v[i*8 +: 8] = 8'(i*17 + 3 + salt*29);
        1: v[i*8 +: 8] = 8'hFF;
        default: v[i*8 +: 8] = 8'((i*53 + salt*91 + 7) % 256);
      endcase
    return v;
  endfunction

  task automatic t_reset;
    check("R12 row_valid", 64'(row_valid), 64'd0);
    check("R12 done", 64'(done), 64'd0);
    check("R12 plane_go", 64'(plane_go), 64'd0);
  endtask

  task automatic t_horizontal;
    for (int p = 0; p < 3; p++) begin
      issue(8'h01, 1'b1, 1'b1, 1'b1, pattern(p, 0), pattern(p, 1));
      check_block("R5", 1, 1'b1, 1'b1, 1'b1, pattern(p, 0), pattern(p, 1), -1);
    end
  endtask

  task automatic t_vertical;
    for (int p = 0; p < 3; p++) begin
      issue(8'h02, 1'b0, 1'b0, 1'b0, pattern(p, 2), pattern(p, 3));
      check_block("R6", 2, 1'b0, 1'b0, 1'b0, pattern(p, 2), pattern(p, 3), -1);
    end
  endtask

  task automatic t_dc_all_flags;
    for (int p = 0; p < 3; p++)
      for (int f = 0; f < 8; f++) begin
        logic ta = f[2]; logic ua = f[1]; logic da = f[0];
        issue(8'h00, ta, ua, da, pattern(p, f), pattern(p, f + 5));
        check_block("R7 DC", 0, ta, ua, da, pattern(p, f), pattern(p, f + 5), -1);
      end
  endtask

  task automatic t_mode_upper_bits;
    issue(8'hF5, 1'b1, 1'b1, 1'b1, pattern(2, 4), pattern(0, 6));
    check_block("R1 hor", 1, 1'b1, 1'b1, 1'b1, pattern(2, 4), pattern(0, 6), -1);
    issue(8'hAC, 1'b1, 1'b0, 1'b1, pattern(0, 4), pattern(2, 6));
    check_block("R1 DC", 0, 1'b1, 1'b0, 1'b1, pattern(0, 4), pattern(2, 6), -1);
  endtask

  task automatic t_busy_ignore;
    issue(8'h02, 1'b1, 1'b1, 1'b1, pattern(0, 7), pattern(2, 8));
    check_block("R4 vert", 2, 1'b1, 1'b1, 1'b1, pattern(0, 7), pattern(2, 8), 3);
  endtask

  task automatic t_plane;
    issue(8'h07, 1'b1, 1'b1, 1'b1, pattern(0, 1), pattern(0, 2));
    check("R11 plane_go", 64'(plane_go), 64'd1);
    check("R11 no rows", 64'(row_valid), 64'd0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check("R11 plane_go pulse", 64'(plane_go), 64'd0);
      check("R11 no rows", 64'(row_valid), 64'd0);
      check("R11 no done", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_horizontal();
    t_vertical();
    t_dc_all_flags();
    t_mode_upper_bits();
    t_busy_ignore();
    t_plane();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule